// File: doc/BRIEF.md
# Serial Byte-Addressed Memory Slave

This block is a serial-peripheral slave that fronts a byte-wide storage array with no wait states. A bus master selects it by pulling the active-low select low and then shifts in an 8-bit command. Read and write commands carry a 16-bit address, sent high byte first. Any number of data bytes then follow, and the address advances by one after each byte. A written byte goes into the array as soon as its eighth bit has arrived, so the master never has to poll for completion. Writes are gated by a write-permission latch, which two further commands set and clear.

The serial pins are sampled with the system clock through a short synchronizer, and all protocol state lives in that clock domain. Bus clock polarities idle-low and idle-high are both accepted: input bits are taken on rising serial-clock edges, and output bits change on falling edges. The serial output is presented as a data bit plus a separate enable for an external tri-state pad. The array depth is `2**ADDR_W` bytes. The full-size instance uses `ADDR_W = 15`, which gives 32 KiB, and the default of 11 keeps elaboration small. Address bits above `ADDR_W-1` are dropped.

Top module: `spimem_slave`

## Requirements
- R1: Out of reset the output enable `spi_miso_oe` is 0 and `spi_miso` is 0.
- R2: While `spi_cs_n` is high, `spi_miso_oe` stays 0, and serial clock and data activity changes neither the array nor the write-permission latch. While it is low, `spi_miso_oe` is 1.
- R3: Command 0x06 sets the write-permission latch and 0x04 clears it. A write command (0x02) changes the array only while the latch is set.
- R4: A write command (0x02, address high byte, address low byte, data) stores each full data byte, MSB first, taken on rising serial-clock edges, and a read issued straight afterwards returns it.
- R5: A read command (0x03, address high byte, address low byte) drives the first data bit, the MSB, after the falling edge that follows the last address bit. Each later bit changes on a falling edge.
- R6: During a read or write burst the address increments after every byte and wraps from `2**ADDR_W-1` to 0.
- R7: Of the 16 address bits received, only the low `ADDR_W` bits select the byte, and the upper bits are ignored.
- R8: Deselecting after a write command clears the write-permission latch, so a second write without a new 0x06 has no effect.
- R9: Only the first byte of a select window is decoded as a command. An unknown command, or a completed 0x06 or 0x04, causes the rest of the window to be ignored.
- R10: If select rises partway through a write data byte, that partial byte is discarded and the array location is unchanged.
- R11: The block works with the serial clock idling low and with it idling high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Output enable for the external tri-state pad |

## Verification
The hardest case to reach from the pins is a select window that ends partway through a data byte. The bench can only see this indirectly, because a location that stays unchanged looks the same as a write that never happened. The stimulus therefore first stores a known pattern at the neighbouring address. It then runs a write burst whose second byte is cut off after four bits, and reads both locations back. The latch rules are tested the same way through outcomes: an ignored second command in one window, an unknown command followed by a byte that would clear the latch, and a full write pattern clocked in while deselected. Each of these is followed by a write or a read whose result shows whether the latch changed.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    // Command byte encodings
    localparam logic [7:0] CMD_SET_WEL = 8'h06;
    localparam logic [7:0] CMD_CLR_WEL = 8'h04;
    localparam logic [7:0] CMD_RD      = 8'h03;
    localparam logic [7:0] CMD_WR      = 8'h02;

    // Protocol phase within one select window
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic sel_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic mosi_o
);

    logic [STAGES-1:0] cs_d,   cs_q;
    logic [STAGES:0]   sck_d,  sck_q;
    logic [STAGES-1:0] mosi_d, mosi_q;

    always_comb begin
        cs_d   = {cs_q[STAGES-2:0], cs_n_i};
        sck_d  = {sck_q[STAGES-1:0], sck_i};
        mosi_d = {mosi_q[STAGES-2:0], mosi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            cs_q   <= cs_d;
            sck_q  <= sck_d;
            mosi_q <= mosi_d;
        end
    end

    // The select, clock and data taps sit at the same depth, so they stay aligned
    assign sel_o      = ~cs_q[STAGES-1];
    assign sck_rise_o =  sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall_o = ~sck_q[STAGES-1] &  sck_q[STAGES];
    assign mosi_o     =  mosi_q[STAGES-1];

endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // The array has no reset; the read port is registered every cycle
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
    import spimem_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          mosi_i,
    input  logic [7:0]    rdata_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic [AW-1:0] raddr_o,
    output logic          miso_o,
    output logic          wel_o
);

    typedef struct packed {
        phase_e        ph;
        logic [2:0]    bit_cnt;
        logic          hi_done;
        logic [7:0]    rx;
        logic [7:0]    tx;
        logic [AW-1:0] addr;
        logic [7:0]    cmd;
        logic          wel;
    } ctrl_st_t;

    localparam ctrl_st_t CTRL_RST = '{
        ph: PH_CMD, bit_cnt: 3'd0, hi_done: 1'b0, rx: 8'h00,
        tx: 8'h00, addr: '0, cmd: 8'h00, wel: 1'b0
    };

    ctrl_st_t st_d, st_q;
    logic [7:0] rx_nxt;

    always_comb begin
        st_d    = st_q;
        rx_nxt  = {st_q.rx[6:0], mosi_i};
        we_o    = 1'b0;
        wdata_o = rx_nxt;
        waddr_o = st_q.addr;

        if (!sel_i) begin
            // Window closed: reset the framing, and drop the latch after a write command
            st_d.ph      = PH_CMD;
            st_d.bit_cnt = 3'd0;
            st_d.hi_done = 1'b0;
            st_d.tx      = 8'h00;
            st_d.cmd     = 8'h00;
            if (st_q.cmd == CMD_WR) begin
                st_d.wel = 1'b0;
            end
        end else begin
            if (rise_i) begin
                st_d.rx      = rx_nxt;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                unique case (st_q.ph)
                    PH_CMD: begin
                        if (st_q.bit_cnt == 3'd7) begin
                            st_d.cmd = rx_nxt;
                            case (rx_nxt)
                                CMD_SET_WEL: begin
                                    st_d.wel = 1'b1;
                                    st_d.ph  = PH_IDLE;
                                end
                                CMD_CLR_WEL: begin
                                    st_d.wel = 1'b0;
                                    st_d.ph  = PH_IDLE;
                                end
                                CMD_RD, CMD_WR: begin
                                    st_d.ph = PH_ADDR;
                                end
                                default: begin
                                    st_d.ph = PH_IDLE;
                                end
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        // Shift all 16 bits through; only the low AW survive
                        st_d.addr = {st_q.addr[AW-2:0], mosi_i};
                        if (st_q.bit_cnt == 3'd7) begin
                            st_d.hi_done = 1'b1;
                            if (st_q.hi_done) begin
                                st_d.ph = PH_DATA;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (st_q.bit_cnt == 3'd7) begin
                            we_o      = (st_q.cmd == CMD_WR) && st_q.wel;
                            st_d.addr = st_q.addr + AW'(1);
                        end
                    end
                    default: begin
                    end
                endcase
            end

            if (fall_i && (st_q.ph == PH_DATA) && (st_q.cmd == CMD_RD)) begin
                // A byte boundary loads the prefetched byte; otherwise shift
                if (st_q.bit_cnt == 3'd0) begin
                    st_d.tx = rdata_i;
                end else begin
                    st_d.tx = {st_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr_o = st_q.addr;
    assign miso_o  = st_q.tx[7];
    assign wel_o   = st_q.wel;

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);

    logic              sel_w;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_rdata;
    logic              wel;
    logic              miso_bit;

    spimem_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (spi_cs_n),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .sel_o      (sel_w),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .mosi_o     (mosi_s)
    );

    spimem_ctrl #(
        .AW (ADDR_W)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_w),
        .rise_i  (sck_rise),
        .fall_i  (sck_fall),
        .mosi_i  (mosi_s),
        .rdata_i (mem_rdata),
        .we_o    (mem_we),
        .waddr_o (mem_waddr),
        .wdata_o (mem_wdata),
        .raddr_o (mem_raddr),
        .miso_o  (miso_bit),
        .wel_o   (wel)
    );

    spimem_array #(
        .AW (ADDR_W),
        .DW (8)
    ) i_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    assign spi_miso    = miso_bit;
    assign spi_miso_oe = sel_w;

endmodule

// File: rtl/spimem_chk.sv
module spimem_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs_n,
    input logic          spi_miso_oe,
    input logic          sel,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic [AW-1:0] mem_raddr,
    input logic          wel
);

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R2

    AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel); // R3

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R4

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_raddr == AW'($past(mem_waddr) + 1'b1))); // R6

    AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sel); // R10

endmodule

bind spimem_slave spimem_chk #(
    .AW (ADDR_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .sel         (sel_w),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_raddr   (mem_raddr),
    .wel         (wel)
);

// File: tb/test_spimem_slave.sv
`timescale 1ns/1ps
module test_spimem_slave;

    localparam int AW   = 11;
    localparam int HALF = 8;

    typedef struct packed {
        logic [15:0] wa;
        logic [15:0] ra;
        logic [7:0]  d;
        logic        m3;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'h0010, 16'h0010, 8'hA5, 1'b0},
        '{16'h0123, 16'h0123, 8'h3C, 1'b1},
        '{16'h8200, 16'h0200, 8'h81, 1'b0},
        '{16'hF455, 16'h0455, 8'h7E, 1'b1},
        '{16'h07FF, 16'h07FF, 8'hFF, 1'b0},
        '{16'h0000, 16'h8000, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;
    logic mode3 = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #2 clk = ~clk;

    spimem_slave #(
        .ADDR_W      (AW),
        .SYNC_STAGES (2)
    ) i_spimem_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (cs_n),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cs_begin();
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        if (!mode3) sck = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nb; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck   = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_begin();
        xfer_bits(op, 8, r);
        cs_end();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] extra);
        logic [7:0] r;
        cs_begin();
        xfer_bits(op, 8, r);
        xfer_bits(extra, 8, r);
        cs_end();
    endtask

    task automatic write_bytes(input logic [15:0] a, input logic [31:0] dat, input int n);
        logic [7:0] r;
        cs_begin();
        xfer_bits(8'h02, 8, r);
        xfer_bits(a[15:8], 8, r);
        xfer_bits(a[7:0], 8, r);
        for (int k = 0; k < n; k++) xfer_bits(dat[31-8*k -: 8], 8, r);
        cs_end();
    endtask

    task automatic read_bytes(input logic [15:0] a, input int n, output logic [31:0] q);
        logic [7:0] r;
        q = 32'h0;
        cs_begin();
        xfer_bits(8'h03, 8, r);
        xfer_bits(a[15:8], 8, r);
        xfer_bits(a[7:0], 8, r);
        for (int k = 0; k < n; k++) begin
            xfer_bits(8'h00, 8, r);
            q[31-8*k -: 8] = r;
        end
        cs_end();
    endtask

    task automatic desel_bits(input logic [31:0] pat);
        for (int i = 31; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = pat[i];
            wait_clk(HALF);
            sck  = 1'b1;
            if (i == 16) check("R2 oe while deselected", {31'h0, miso_oe}, 32'h0);
            wait_clk(HALF);
        end
        sck = mode3;
        wait_clk(HALF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] q;
        logic [7:0]  r;

        // R1: reset state
        wait_clk(5);
        check("R1 oe in reset", {31'h0, miso_oe}, 32'h0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 oe after reset", {31'h0, miso_oe}, 32'h0);
        check("R1 miso after reset", {31'h0, miso}, 32'h0);

        // Vector table: enable, single-byte write, read back
        for (int i = 0; i < 6; i++) begin
            mode3 = VEC[i].m3;
            cmd1(8'h06);
            write_bytes(VEC[i].wa, {VEC[i].d, 24'h0}, 1);
            read_bytes(VEC[i].ra, 1, q);
            if (VEC[i].wa != VEC[i].ra)
                check("R7 alias read", {24'h0, q[31:24]}, {24'h0, VEC[i].d});
            else if (VEC[i].m3)
                check("R11 idle-high write/read", {24'h0, q[31:24]}, {24'h0, VEC[i].d});
            else
                check("R4 write/read", {24'h0, q[31:24]}, {24'h0, VEC[i].d});
        end
        mode3 = 1'b0;

        // R5: first data bit after the last address falling edge; oe while selected (R2)
        cs_begin();
        check("R2 oe while selected", {31'h0, miso_oe}, 32'h1);
        xfer_bits(8'h03, 8, r);
        xfer_bits(8'h00, 8, r);
        xfer_bits(8'h10, 8, r);
        xfer_bits(8'h00, 8, r);
        cs_end();
        check("R5 first read byte", {24'h0, r}, 32'hA5);

        // R6: burst write across the top, burst read back, then the wrapped location
        cmd1(8'h06);
        write_bytes(16'h07FE, 32'h11223344, 4);
        read_bytes(16'h07FE, 4, q);
        check("R6 burst wrap", q, 32'h11223344);
        read_bytes(16'h0000, 1, q);
        check("R6 wrapped location", {24'h0, q[31:24]}, 32'h33);

        // R11: idle-high burst read across the wrap
        mode3 = 1'b1;
        read_bytes(16'h07FF, 2, q);
        check("R11 idle-high burst", {16'h0, q[31:16]}, 32'h2233);
        mode3 = 1'b0;

        // R8: latch drops after a write window
        cmd1(8'h06);
        write_bytes(16'h0030, 32'h5A000000, 1);
        write_bytes(16'h0030, 32'hC3000000, 1);
        read_bytes(16'h0030, 1, q);
        check("R8 second write blocked", {24'h0, q[31:24]}, 32'h5A);

        // R3: clear latch blocks writes, set latch allows them
        cmd1(8'h06);
        write_bytes(16'h0031, 32'h10000000, 1);
        cmd1(8'h06);
        cmd1(8'h04);
        write_bytes(16'h0031, 32'h77000000, 1);
        read_bytes(16'h0031, 1, q);
        check("R3 write blocked after clear", {24'h0, q[31:24]}, 32'h10);
        cmd1(8'h06);
        write_bytes(16'h0031, 32'h77000000, 1);
        read_bytes(16'h0031, 1, q);
        check("R3 write after set", {24'h0, q[31:24]}, 32'h77);

        // R9: unknown command then a clear byte; the latch must survive
        cmd1(8'h06);
        cmd2(8'hAB, 8'h04);
        write_bytes(16'h0031, 32'h99000000, 1);
        read_bytes(16'h0031, 1, q);
        check("R9 unknown command ignored", {24'h0, q[31:24]}, 32'h99);
        // R9: clear then a set byte in one window; the set must be ignored
        cmd2(8'h04, 8'h06);
        write_bytes(16'h0031, 32'h55000000, 1);
        read_bytes(16'h0031, 1, q);
        check("R9 second command ignored", {24'h0, q[31:24]}, 32'h99);

        // R2: a full write pattern while deselected changes nothing
        cmd1(8'h06);
        desel_bits(32'h02003166);
        cmd1(8'h04);
        read_bytes(16'h0031, 1, q);
        check("R2 deselected traffic ignored", {24'h0, q[31:24]}, 32'h99);
        desel_bits(32'h06060606);
        write_bytes(16'h0031, 32'h44000000, 1);
        read_bytes(16'h0031, 1, q);
        check("R2 latch untouched while deselected", {24'h0, q[31:24]}, 32'h99);

        // R10: partial data byte at deselect is dropped
        cmd1(8'h06);
        write_bytes(16'h0041, 32'h12000000, 1);
        cmd1(8'h06);
        cs_begin();
        xfer_bits(8'h02, 8, r);
        xfer_bits(8'h00, 8, r);
        xfer_bits(8'h40, 8, r);
        xfer_bits(8'hE1, 8, r);
        xfer_bits(8'hFF, 4, r);
        cs_end();
        read_bytes(16'h0040, 2, q);
        check("R10 full byte kept", {24'h0, q[31:24]}, 32'hE1);
        check("R10 partial byte dropped", {24'h0, q[23:16]}, 32'h12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule